// File: doc/BRIEF.md
# Two-Bank Pin Controller with Edge Interrupts

This block controls 64 general-purpose pins. The pins are grouped into two banks of 32, and pin n belongs to bank n/32 at bit n%32. Each pin has three pieces of state: a direction bit, an output latch and a sampled input level. Software reaches all of it through a plain 32-bit register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr`.

The output latches never change through an ordinary write. Software writes a one to a set word or to a clear word instead. Edge-status bits are cleared in the same way, by writing a one to the bit. Because of this, no register ever needs a read-modify-write.

Each pin has a rising-edge enable and a falling-edge enable. An enabled edge sets a sticky status bit. A single level interrupt stays high while any status bit in either bank is set.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe`=0), every output latch is 0 (`pin_out`=0), all edge enables are 0, all status bits are 0 and `irq` is 0.
- R2: Word addresses run in kind order, and each kind has a bank-0 word followed by a bank-1 word. The byte offsets are: level 0x00/0x04, direction 0x08/0x0C, output-set 0x10/0x14, output-clear 0x18/0x1C, rise-enable 0x20/0x24, fall-enable 0x28/0x2C, edge-status 0x30/0x34. In every word, bit b of bank k stands for pin 32k+b.
- R3: The level word returns each pin input after a two-flop synchroniser. A change applied before rising edge 1 reads back after rising edge 2 and not after rising edge 1.
- R4: The direction words read back what was written. Bit value 1 drives `pin_oe` high (output) and 0 makes the pin an input.
- R5: Writing a 1 to a set-word bit raises that pin's latch. Writing a 1 to a clear-word bit lowers it. Zero bits leave the latch unchanged. `pin_out` shows the latches.
- R6: With its rise enable at 1, a rising pin sets that pin's status bit on the third clock edge after the change. The fall enable does the same for falling pins, and both enables may be set together.
- R7: An edge whose enable bit is 0 leaves the status bit at 0.
- R8: Writing a 1 to a status bit clears it, and zero bits leave it unchanged. If a new enabled edge arrives in the same cycle as the clearing write, the bit stays set.
- R9: `irq` is high exactly while at least one status bit of either bank is set.
- R10: The set and clear words read 0. Offsets 0x38 and 0x3C read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 6 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 64 | Pin input levels, asynchronous |
| pin_out | output | 64 | Output latches |
| pin_oe | output | 64 | Output enables (direction bits) |
| irq | output | 1 | Level interrupt, any status bit set |

## Verification
The assertions assume the following about the inputs:
- At most one register access happens per cycle.
- Pin inputs may change at any time, because they pass through the synchroniser.
- A fall of `irq` always has a status-clearing write one cycle earlier.

The stimulus keeps within these rules:
- It changes pins and bus signals only on falling clock edges.
- It issues one write at a time.
- Every status clear goes through the status words.
- Edges and clearing writes are lined up by counting rising edges from the pin change, and this includes the single cycle in which the edge and the clearing write coincide.

// File: rtl/gpio_ctl_pkg.sv
`timescale 1ns/1ps
package gpio_ctl_pkg;

  typedef enum logic [2:0] {
    K_LEVEL = 3'd0,
    K_DIR   = 3'd1,
    K_SET   = 3'd2,
    K_CLR   = 3'd3,
    K_RISE  = 3'd4,
    K_FALL  = 3'd5,
    K_STAT  = 3'd6
  } reg_kind_e;

  localparam int unsigned NUM_KINDS = 7;

  // register kind from a word index: upper bits above the bank field
  function automatic logic [15:0] kind_of(input logic [15:0] word, input int unsigned bank_bits);
    return word >> bank_bits;
  endfunction

  // bank number from a word index: the low bank field
  function automatic logic [15:0] bank_of(input logic [15:0] word, input int unsigned bank_bits);
    return word & 16'((32'd1 << bank_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic         wr_ack,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q
);
  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] now, input logic [W-1:0] was,
                                             input logic [W-1:0] ren, input logic [W-1:0] fen);
    return (now & ~was & ren) | (~now & was & fen);
  endfunction

  logic [W-1:0] evt;       // enabled edges seen this cycle
  logic [W-1:0] ack_mask;  // status bits being cleared this cycle

  assign evt      = edge_hits(lvl, lvl_prev, rise_q, fall_q);
  assign ack_mask = wr_ack ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_set)      out_q <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
      if (wr_rise) rise_q <= wdata;
      if (wr_fall) fall_q <= wdata;
      stat_q <= (stat_q & ~ack_mask) | evt;  // new edge wins over clear
    end
  end

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wdata)) == '0));
  p_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_mask != '0) && (evt == '0)) |=> ((stat_q & $past(ack_mask)) == '0));
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/gpio_dual_bank.sv
`timescale 1ns/1ps
module gpio_dual_bank
  import gpio_ctl_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int BANK_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BANK_W-1:0]       bus_wdata,
  output logic [BANK_W-1:0]       bus_rdata,
  input  logic [BANKS*BANK_W-1:0] pin_in,
  output logic [BANKS*BANK_W-1:0] pin_out,
  output logic [BANKS*BANK_W-1:0] pin_oe,
  output logic                    irq
);
  localparam int NPINS = BANKS * BANK_W;
  localparam int BB    = $clog2(BANKS);
  localparam int BIW   = (BB == 0) ? 1 : BB;

  logic [NPINS-1:0] lvl, lvl_prev;
  logic [15:0]      word, kind, bank;
  logic [BIW-1:0]   bidx;
  logic             we, mapped, stat_wr;

  logic [BANKS-1:0][BANK_W-1:0] dir_a, out_a, rise_a, fall_a, stat_a;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl), .q_prev(lvl_prev)
  );

  assign word    = 16'(bus_addr[ADDR_W-1:2]);
  assign kind    = kind_of(word, BB);
  assign bank    = bank_of(word, BB);
  assign bidx    = bank[BIW-1:0];
  assign mapped  = (kind < 16'(NUM_KINDS)) && (bank < 16'(BANKS));
  assign we      = bus_sel && bus_wr && mapped;
  assign stat_wr = we && (kind == 16'(K_STAT));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bw;
    assign bw = we && (bank == 16'(b));
    gpio_bank #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_dir (bw && (kind == 16'(K_DIR))),
      .wr_set (bw && (kind == 16'(K_SET))),
      .wr_clr (bw && (kind == 16'(K_CLR))),
      .wr_rise(bw && (kind == 16'(K_RISE))),
      .wr_fall(bw && (kind == 16'(K_FALL))),
      .wr_ack (bw && (kind == 16'(K_STAT))),
      .wdata(bus_wdata),
      .lvl(lvl[b*BANK_W +: BANK_W]),
      .lvl_prev(lvl_prev[b*BANK_W +: BANK_W]),
      .dir_q(dir_a[b]), .out_q(out_a[b]), .rise_q(rise_a[b]),
      .fall_q(fall_a[b]), .stat_q(stat_a[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      case (kind[2:0])
        K_LEVEL: bus_rdata = lvl[bidx*BANK_W +: BANK_W];
        K_DIR:   bus_rdata = dir_a[bidx];
        K_RISE:  bus_rdata = rise_a[bidx];
        K_FALL:  bus_rdata = fall_a[bidx];
        K_STAT:  bus_rdata = stat_a[bidx];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_a;
  assign pin_out = out_a;
  assign irq     = |stat_a;

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !mapped) |=> ($stable(dir_a) && $stable(out_a) &&
                                        $stable(rise_a) && $stable(fall_a)));
endmodule

// File: tb/test_gpio_dual_bank.sv
`timescale 1ns/1ps
module test_gpio_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq;
  logic [31:0] rv;
  int total = 0;
  int bad = 0;

  gpio_dual_bank i_gpio_dual_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2 clk = ~clk;  // 250 MHz

  // kinds: 0 level,1 dir,2 set,3 clr,4 rise,5 fall,6 status
  function automatic logic [5:0] off(input int kind, input int bank);
    return 6'((kind * 2 + bank) * 4);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pin_in[n] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 7; k++)
      for (int b = 0; b < 2; b++) begin
        rd(off(k, b), rv);
        chk("R1 reg zero", 64'(rv), 64'd0);
      end
    chk("R1 oe", pin_oe, 64'd0);
    chk("R1 out", pin_out, 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);

    // R4 / R2 direction per bank
    wr(off(1, 0), 32'hA5A5_0F0F);
    wr(off(1, 1), 32'h1234_8001);
    rd(off(1, 0), rv); chk("R4 dir0 readback", 64'(rv), 64'hA5A5_0F0F);
    rd(off(1, 1), rv); chk("R4 dir1 readback", 64'(rv), 64'h1234_8001);
    chk("R4 R2 pin_oe", pin_oe, 64'h1234_8001_A5A5_0F0F);

    // R5 set and clear, zeros leave latch
    wr(off(2, 0), 32'hF0F0_F0F0);
    wr(off(2, 1), 32'h0000_00FF);
    chk("R5 set", pin_out, 64'h0000_00FF_F0F0_F0F0);
    wr(off(2, 0), 32'h0000_000F);
    chk("R5 set merge", pin_out, 64'h0000_00FF_F0F0_F0FF);
    wr(off(3, 0), 32'h3000_0003);
    wr(off(3, 1), 32'h0000_0080);
    chk("R5 clear", pin_out, 64'h0000_007F_C0F0_F0FC);
    // R10 set/clear read zero
    rd(off(2, 0), rv); chk("R10 set reads 0", 64'(rv), 64'd0);
    rd(off(3, 1), rv); chk("R10 clr reads 0", 64'(rv), 64'd0);

    // R3 synchroniser latency
    @(negedge clk) pin_in = 64'hDEAD_BEEF_0BAD_F00D;
    @(posedge clk);
    rd(off(0, 0), rv); chk("R3 level after 1 edge", 64'(rv), 64'd0);
    @(posedge clk);
    rd(off(0, 0), rv); chk("R3 level0 after 2 edges", 64'(rv), 64'h0BAD_F00D);
    rd(off(0, 1), rv); chk("R3 level1", 64'(rv), 64'hDEAD_BEEF);
    @(negedge clk) pin_in = '0;
    repeat (3) @(posedge clk);

    // R6 / R7 / R8 / R9 rising-only sweep over all pins
    wr(off(4, 0), 32'hFFFF_FFFF);
    wr(off(4, 1), 32'hFFFF_FFFF);
    for (int n = 0; n < 64; n++) begin
      set_pin(n, 1'b1);
      repeat (3) @(posedge clk);
      rd(off(6, n / 32), rv);
      chk("R6 rise status", 64'(rv), 64'(32'd1 << (n % 32)));
      chk("R9 irq high", 64'(irq), 64'd1);
      rd(off(6, 1 - n / 32), rv);
      chk("R2 other bank clear", 64'(rv), 64'd0);
      wr(off(6, n / 32), 32'd1 << (n % 32));
      rd(off(6, n / 32), rv);
      chk("R8 ack clears", 64'(rv), 64'd0);
      chk("R9 irq low", 64'(irq), 64'd0);
      set_pin(n, 1'b0);
      repeat (3) @(posedge clk);
      rd(off(6, n / 32), rv);
      chk("R7 fall disabled", 64'(rv), 64'd0);
    end

    // falling-only sweep
    wr(off(4, 0), 32'd0);
    wr(off(4, 1), 32'd0);
    wr(off(5, 0), 32'hFFFF_FFFF);
    wr(off(5, 1), 32'hFFFF_FFFF);
    for (int n = 0; n < 64; n++) begin
      set_pin(n, 1'b1);
      repeat (3) @(posedge clk);
      rd(off(6, n / 32), rv);
      chk("R7 rise disabled", 64'(rv), 64'd0);
      set_pin(n, 1'b0);
      repeat (3) @(posedge clk);
      rd(off(6, n / 32), rv);
      chk("R6 fall status", 64'(rv), 64'(32'd1 << (n % 32)));
      wr(off(6, n / 32), 32'd1 << (n % 32));
    end

    // R6 both enables, R8 partial ack and edge-vs-ack race
    wr(off(4, 1), 32'hFFFF_FFFF);
    set_pin(40, 1'b1);
    set_pin(45, 1'b1);
    repeat (3) @(posedge clk);
    rd(off(6, 1), rv); chk("R6 both rise", 64'(rv), 64'h0000_2100);
    wr(off(6, 1), 32'h0000_0100);
    rd(off(6, 1), rv); chk("R8 zero bits kept", 64'(rv), 64'h0000_2000);
    chk("R9 irq with one bit", 64'(irq), 64'd1);
    set_pin(45, 1'b0);
    @(posedge clk);
    @(posedge clk);
    wr(off(6, 1), 32'h0000_2000);  // lands on the same edge as the fall
    rd(off(6, 1), rv); chk("R8 edge wins over ack", 64'(rv), 64'h0000_2000);
    wr(off(6, 1), 32'h0000_2000);
    rd(off(6, 1), rv); chk("R8 later ack clears", 64'(rv), 64'd0);
    chk("R9 irq dropped", 64'(irq), 64'd0);

    // R10 unmapped offsets
    wr(6'h38, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h38, rv); chk("R10 0x38 reads 0", 64'(rv), 64'd0);
    rd(6'h3C, rv); chk("R10 0x3C reads 0", 64'(rv), 64'd0);
    chk("R10 oe unchanged", pin_oe, 64'h1234_8001_A5A5_0F0F);
    chk("R10 out unchanged", pin_out, 64'h0000_007F_C0F0_F0FC);
    rd(off(4, 0), rv); chk("R10 rise0 unchanged", 64'(rv), 64'd0);
    rd(off(5, 0), rv); chk("R10 fall0 unchanged", 64'(rv), 64'hFFFF_FFFF);
    chk("R10 irq unchanged", 64'(irq), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule